// File: doc/BRIEF.md
# PLL Bring-up Sequencer

This block is a state machine that brings a clock-generating PLL into service by issuing register writes in a strict order. Software places the divider settings on its inputs: input divider M, feedback divider N, post-divider exponent P (the output is Fin / M * N / 2^P), the charge-pump setting and four secondary-output ratios. It then pulses `start_i`. The sequencer first parks the system clock on the raw oscillator. It loads the dividers with the bypass bit set, writes the charge pump, turns the PLL on while still bypassed, and releases bypass. It then waits a fixed number of cycles for lock. Next it brings up the secondary output dividers one register at a time, each with a reset write followed by a configure write. Last, it moves the system clock onto a divided PLL output and raises `done_o`.

For a target flagged as override-checked, the sequencer reads the live base register value on `base_rdback_i` when it accepts `start_i`. If that value already has the override bit set, the PLL is left alone: the base and charge-pump writes and the settle wait are skipped. The live value is compared with the value the request would have produced, and a sticky configuration-valid flag is cleared when they differ. The output dividers and the clock-source switches still run.

Every write leaves through a valid/ready port that carries an address and a data word. The PLL is modelled as registers behind this port.

Top module: `pll_bringup_seq`

## Requirements
- R1: After reset, `busy_o`=0, `done_o`=0, `wr_valid_o`=0, `skipped_o`=0 and `cfg_ok_o`=1.
- R2: A `start_i` pulse accepted while idle makes the first write go to address 0 (system clock source) with data 0, which selects the oscillator.
- R3: In a programming run, the second write goes to address 1 (base). Its data holds M at bits [4:0], N at [17:8] and P at [22:20], with bit 31 (bypass) set and bit 30 (enable) clear. Bit 28 (override) is set exactly when `tgt_ovr_chk_i` was 1.
- R4: The third write goes to address 2 (misc) with the charge-pump value at bits [11:8] and all other bits zero.
- R5: The fourth write is the R3 word with bit 30 set. The fifth write is the R3 word with bit 30 set and bit 31 cleared.
- R6: After the fifth write, no write is offered for SETTLE_CYC cycles. When ready is held high, the next handshake comes exactly SETTLE_CYC+1 cycles after the fifth one.
- R7: Output dividers are written to address 3 (channel 1 in bits [15:0], channel 2 in bits [31:16]) and then to address 4 (channel 3 low half, channel 4 high half). Each address gets two writes. The first is 0x0001_0001 (bit 0 of each half = divider reset). The second has, in each half, the ratio at bits [15:8], bit 2 (override) and bit 1 (clock enable) set, and bit 0 clear.
- R8: The last write goes to address 0 with data 1 (divided PLL output). `done_o` rises the cycle after its handshake, and `busy_o` falls at the same time.
- R9: If `tgt_ovr_chk_i`=1 and bit 28 of `base_rdback_i` is set at start, the run is SYSCLK←0, the four R7 writes, SYSCLK←1, with no settle wait, and `skipped_o`=1. Otherwise `skipped_o`=0.
- R10: In a skipped run, if `base_rdback_i` differs from the R5 fifth-write word, `cfg_ok_o` goes to 0 and stays 0 until reset. A matching value leaves it unchanged.
- R11: `start_i` while `busy_o`=1 is ignored. The writes use the settings captured at the accepted start, even if the inputs change later.
- R12: While `wr_valid_o`=1 and `wr_ready_i`=0, valid, address and data hold steady to the next cycle.
- R13: `busy_o` is 1 from the cycle after an accepted start until completion. An accepted start clears `done_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Begin a bring-up sequence (taken only when idle) |
| tgt_ovr_chk_i | input | 1 | Target PLL is subject to the override check |
| div_in_i | input | M_W | Input divider M |
| div_fb_i | input | N_W | Feedback divider N |
| div_post_i | input | P_W | Post-divider exponent P |
| pump_i | input | CP_W | Charge-pump setting |
| ratios_i | input | 4*RATIO_W | Secondary output ratios, channel 1 in the lowest slice |
| base_rdback_i | input | 32 | Live value of the PLL base register |
| wr_ready_i | input | 1 | Register port accepts the write |
| wr_valid_o | output | 1 | Write offered |
| wr_addr_o | output | 3 | Write address |
| wr_data_o | output | 32 | Write data |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | Last sequence finished |
| cfg_ok_o | output | 1 | Sticky flag: no override mismatch seen |
| skipped_o | output | 1 | Last accepted start skipped PLL programming |

## Verification
The hardest case to reach is the override path. It only occurs when the target is flagged and the sampled read-back word has bit 28 set. The mismatch branch also needs that word to differ from a request-derived value that the ports never show. The stimulus builds the read-back word from the same bench function that predicts the fifth base write, so it can give either an exact match or a deliberately perturbed one. The random mix then exercises the settle gap and the output write order under random ready stalls.

// File: rtl/pll_seq_pkg.sv
// Package: shared constants and state type for the PLL bring-up sequencer.
// Assumes 32-bit register words and a 3-bit register address.
package pll_seq_pkg;
    localparam int ADDR_W = 3;
    localparam int DATA_W = 32;

    // register addresses
    localparam logic [ADDR_W-1:0] A_SYSCLK = 3'd0;
    localparam logic [ADDR_W-1:0] A_BASE   = 3'd1;
    localparam logic [ADDR_W-1:0] A_MISC   = 3'd2;
    localparam logic [ADDR_W-1:0] A_OUT12  = 3'd3;
    localparam logic [ADDR_W-1:0] A_OUT34  = 3'd4;

    // base register fields
    localparam int B_BYPASS = 31;
    localparam int B_ENABLE = 30;
    localparam int B_OVRD   = 28;
    localparam int M_LSB    = 0;
    localparam int N_LSB    = 8;
    localparam int P_LSB    = 20;
    // misc register field
    localparam int CP_LSB   = 8;
    // output-divider half-word fields
    localparam int H_RST       = 0;
    localparam int H_CLKEN     = 1;
    localparam int H_OVRD      = 2;
    localparam int H_RATIO_LSB = 8;

    // system clock source codes
    localparam logic [DATA_W-1:0] SRC_OSC    = 32'd0;
    localparam logic [DATA_W-1:0] SRC_PLLDIV = 32'd1;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_SRC_OSC,
        ST_BASE_BYP,
        ST_MISC,
        ST_BASE_EN,
        ST_BASE_RUN,
        ST_SETTLE,
        ST_OUT12_RST,
        ST_OUT12_CFG,
        ST_OUT34_RST,
        ST_OUT34_CFG,
        ST_SRC_PLL
    } seq_state_t;
endpackage

// File: rtl/pll_seq_word_build.sv
// Module: builds the register words for one bring-up from captured settings.
// Assumes M_W<=8, N_W<=12, P_W<=5, CP_W<=8, RATIO_W<=8 so fields do not overlap.
module pll_seq_word_build
    import pll_seq_pkg::*;
#(
    parameter int M_W     = 5,
    parameter int N_W     = 10,
    parameter int P_W     = 3,
    parameter int CP_W    = 4,
    parameter int RATIO_W = 8
) (
    input  logic                 tgt_i,
    input  logic [M_W-1:0]       m_i,
    input  logic [N_W-1:0]       n_i,
    input  logic [P_W-1:0]       p_i,
    input  logic [CP_W-1:0]      cp_i,
    input  logic [4*RATIO_W-1:0] ratios_i,
    output logic [DATA_W-1:0]    base_req_o,
    output logic [DATA_W-1:0]    misc_o,
    output logic [1:0][DATA_W-1:0] out_cfg_o
);
    localparam int NUM_OUT_REG = 2;

    // Base word: dividers plus override marker for checked targets.
    always_comb begin
        base_req_o = (DATA_W'(m_i) << M_LSB) | (DATA_W'(n_i) << N_LSB) |
                     (DATA_W'(p_i) << P_LSB);
        base_req_o[B_OVRD] = tgt_i;
    end

    // Misc word: charge pump only.
    assign misc_o = DATA_W'(cp_i) << CP_LSB;

    // One configure word per shared output register, two channels each.
    for (genvar g = 0; g < NUM_OUT_REG; g++) begin : g_out
        logic [15:0] lo_half, hi_half;
        always_comb begin
            lo_half = 16'(ratios_i[(2*g)*RATIO_W +: RATIO_W]) << H_RATIO_LSB;
            lo_half[H_OVRD]  = 1'b1;
            lo_half[H_CLKEN] = 1'b1;
            hi_half = 16'(ratios_i[(2*g+1)*RATIO_W +: RATIO_W]) << H_RATIO_LSB;
            hi_half[H_OVRD]  = 1'b1;
            hi_half[H_CLKEN] = 1'b1;
        end
        assign out_cfg_o[g] = {hi_half, lo_half};
    end
endmodule

// File: rtl/pll_seq_settle_timer.sv
// Module: counts the lock-settle interval while the sequencer waits.
// Assumes CYC >= 1; counter clears whenever run is low.
module pll_seq_settle_timer #(
    parameter int CYC = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic expired_o
);
    localparam int CW = (CYC > 1) ? $clog2(CYC) : 1;
    localparam logic [CW-1:0] LAST = CW'(CYC - 1);

    logic [CW-1:0] cnt_q;

    // Advance while waiting, otherwise hold at zero.
    always_ff @(posedge clk) begin
        if (!rst_n || !run_i) cnt_q <= '0;
        else if (cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
    end

    assign expired_o = run_i && (cnt_q == LAST);

    // Counter leaves zero only while waiting (R6).
    assert_cnt_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> cnt_q == '0);
endmodule

// File: rtl/pll_bringup_seq.sv
// Module: top-level PLL bring-up sequencer. Issues ordered register writes
// over a valid/ready port, waits for lock, configures output dividers and
// switches the system clock. Assumes the write target holds data on handshake.
module pll_bringup_seq
    import pll_seq_pkg::*;
#(
    parameter int M_W        = 5,
    parameter int N_W        = 10,
    parameter int P_W        = 3,
    parameter int CP_W       = 4,
    parameter int RATIO_W    = 8,
    parameter int SETTLE_CYC = 20
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start_i,
    input  logic                 tgt_ovr_chk_i,
    input  logic [M_W-1:0]       div_in_i,
    input  logic [N_W-1:0]       div_fb_i,
    input  logic [P_W-1:0]       div_post_i,
    input  logic [CP_W-1:0]      pump_i,
    input  logic [4*RATIO_W-1:0] ratios_i,
    input  logic [31:0]          base_rdback_i,
    input  logic                 wr_ready_i,
    output logic                 wr_valid_o,
    output logic [2:0]           wr_addr_o,
    output logic [31:0]          wr_data_o,
    output logic                 busy_o,
    output logic                 done_o,
    output logic                 cfg_ok_o,
    output logic                 skipped_o
);
    localparam logic [DATA_W-1:0] OUT_RST_W = 32'h0001_0001;

    seq_state_t state_q, state_d;

    logic                 tgt_q;
    logic [M_W-1:0]       m_q;
    logic [N_W-1:0]       n_q;
    logic [P_W-1:0]       p_q;
    logic [CP_W-1:0]      cp_q;
    logic [4*RATIO_W-1:0] ratios_q;
    logic [DATA_W-1:0]    rdback_q;
    logic                 skip_q;

    logic [DATA_W-1:0]    base_req, misc_w, base_en, base_run;
    logic [1:0][DATA_W-1:0] out_cfg;
    logic                 settle_done;
    logic                 start_ok, hs;

    assign start_ok = start_i && (state_q == ST_IDLE);
    assign hs       = wr_valid_o && wr_ready_i;

    pll_seq_word_build #(
        .M_W(M_W), .N_W(N_W), .P_W(P_W), .CP_W(CP_W), .RATIO_W(RATIO_W)
    ) u_words (
        .tgt_i     (tgt_q),
        .m_i       (m_q),
        .n_i       (n_q),
        .p_i       (p_q),
        .cp_i      (cp_q),
        .ratios_i  (ratios_q),
        .base_req_o(base_req),
        .misc_o    (misc_w),
        .out_cfg_o (out_cfg)
    );

    pll_seq_settle_timer #(.CYC(SETTLE_CYC)) u_settle (
        .clk      (clk),
        .rst_n    (rst_n),
        .run_i    (state_q == ST_SETTLE),
        .expired_o(settle_done)
    );

    // Enable-on variants of the base word.
    always_comb begin
        base_en           = base_req;
        base_en[B_BYPASS] = 1'b1;
        base_en[B_ENABLE] = 1'b1;
        base_run           = base_req;
        base_run[B_ENABLE] = 1'b1;
    end

    // Capture settings and read-back value at an accepted start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tgt_q    <= 1'b0;
            m_q      <= '0;
            n_q      <= '0;
            p_q      <= '0;
            cp_q     <= '0;
            ratios_q <= '0;
            rdback_q <= '0;
            skip_q   <= 1'b0;
        end else if (start_ok) begin
            tgt_q    <= tgt_ovr_chk_i;
            m_q      <= div_in_i;
            n_q      <= div_fb_i;
            p_q      <= div_post_i;
            cp_q     <= pump_i;
            ratios_q <= ratios_i;
            rdback_q <= base_rdback_i;
            skip_q   <= tgt_ovr_chk_i && base_rdback_i[B_OVRD];
        end
    end

    // Step through the write order; each write advances on handshake.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:      if (start_ok) state_d = ST_SRC_OSC;
            ST_SRC_OSC:   if (hs) state_d = skip_q ? ST_OUT12_RST : ST_BASE_BYP;
            ST_BASE_BYP:  if (hs) state_d = ST_MISC;
            ST_MISC:      if (hs) state_d = ST_BASE_EN;
            ST_BASE_EN:   if (hs) state_d = ST_BASE_RUN;
            ST_BASE_RUN:  if (hs) state_d = ST_SETTLE;
            ST_SETTLE:    if (settle_done) state_d = ST_OUT12_RST;
            ST_OUT12_RST: if (hs) state_d = ST_OUT12_CFG;
            ST_OUT12_CFG: if (hs) state_d = ST_OUT34_RST;
            ST_OUT34_RST: if (hs) state_d = ST_OUT34_CFG;
            ST_OUT34_CFG: if (hs) state_d = ST_SRC_PLL;
            ST_SRC_PLL:   if (hs) state_d = ST_IDLE;
            default:      state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Write port address and data for the current step.
    always_comb begin
        wr_valid_o = (state_q != ST_IDLE) && (state_q != ST_SETTLE);
        wr_addr_o  = A_SYSCLK;
        wr_data_o  = '0;
        unique case (state_q)
            ST_SRC_OSC:   begin wr_addr_o = A_SYSCLK; wr_data_o = SRC_OSC; end
            ST_BASE_BYP:  begin
                wr_addr_o = A_BASE;
                wr_data_o = base_req;
                wr_data_o[B_BYPASS] = 1'b1;
            end
            ST_MISC:      begin wr_addr_o = A_MISC;  wr_data_o = misc_w;     end
            ST_BASE_EN:   begin wr_addr_o = A_BASE;  wr_data_o = base_en;    end
            ST_BASE_RUN:  begin wr_addr_o = A_BASE;  wr_data_o = base_run;   end
            ST_OUT12_RST: begin wr_addr_o = A_OUT12; wr_data_o = OUT_RST_W;  end
            ST_OUT12_CFG: begin wr_addr_o = A_OUT12; wr_data_o = out_cfg[0]; end
            ST_OUT34_RST: begin wr_addr_o = A_OUT34; wr_data_o = OUT_RST_W;  end
            ST_OUT34_CFG: begin wr_addr_o = A_OUT34; wr_data_o = out_cfg[1]; end
            ST_SRC_PLL:   begin wr_addr_o = A_SYSCLK; wr_data_o = SRC_PLLDIV; end
            default:      ;
        endcase
    end

    // Done flag: set by the final write, cleared by a new start.
    always_ff @(posedge clk) begin
        if (!rst_n)                            done_o <= 1'b0;
        else if (start_ok)                     done_o <= 1'b0;
        else if (state_q == ST_SRC_PLL && hs)  done_o <= 1'b1;
    end

    // Sticky valid flag: cleared on an override mismatch.
    always_ff @(posedge clk) begin
        if (!rst_n) cfg_ok_o <= 1'b1;
        else if (state_q == ST_SRC_OSC && skip_q && rdback_q != base_run)
            cfg_ok_o <= 1'b0;
    end

    assign busy_o    = (state_q != ST_IDLE);
    assign skipped_o = skip_q;

    // Port holds its offer while stalled (R12).
    assert_hold_offer_R12: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid_o && !wr_ready_i |=> wr_valid_o && $stable(wr_addr_o) && $stable(wr_data_o));
    // Bypass is only ever released with enable on (R5).
    assert_release_enabled_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid_o && wr_addr_o == A_BASE && !wr_data_o[B_BYPASS] |-> wr_data_o[B_ENABLE]);
    // Nothing is offered in the cycle after the bypass release (R6).
    assert_settle_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        hs && wr_addr_o == A_BASE && !wr_data_o[B_BYPASS] |=> !wr_valid_o);
    // Done follows the final source switch (R8).
    assert_done_after_switch_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_o) |-> $past(hs && wr_addr_o == A_SYSCLK && wr_data_o == SRC_PLLDIV));
    // Done and busy never overlap (R13).
    assert_done_idle_R13: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_o && busy_o));
    // Valid flag only drops during a run (R10).
    assert_ok_drop_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cfg_ok_o) |-> $past(busy_o));
endmodule

// File: tb/pll_bringup_seq_tb.sv
module pll_bringup_seq_tb;
    localparam int SET = 12;

    logic        clk = 0;
    logic        rst_n = 0;
    logic        start_i = 0;
    logic        tgt = 0;
    logic [4:0]  m_i = 0;
    logic [9:0]  n_i = 0;
    logic [2:0]  p_i = 0;
    logic [3:0]  cp_i = 0;
    logic [31:0] ratios = 0;
    logic [31:0] rdback = 0;
    logic        wr_ready = 1;
    logic        wr_valid, busy, done, cfg_ok, skipped;
    logic [2:0]  wr_addr;
    logic [31:0] wr_data;

    int total = 0, bad = 0, cyc = 0;
    bit ready_rand = 0;
    bit exp_ok = 1;

    logic [2:0]  rec_a [0:31];
    logic [31:0] rec_d [0:31];
    int          rec_c [0:31];
    int          rec_n = 0;
    logic [2:0]  exp_a [0:15];
    logic [31:0] exp_d [0:15];
    int          exp_n;

    pll_bringup_seq #(.SETTLE_CYC(SET)) u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .tgt_ovr_chk_i(tgt),
        .div_in_i(m_i), .div_fb_i(n_i), .div_post_i(p_i), .pump_i(cp_i),
        .ratios_i(ratios), .base_rdback_i(rdback), .wr_ready_i(wr_ready),
        .wr_valid_o(wr_valid), .wr_addr_o(wr_addr), .wr_data_o(wr_data),
        .busy_o(busy), .done_o(done), .cfg_ok_o(cfg_ok), .skipped_o(skipped));

    always #5 clk = ~clk;

    task automatic check(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] base_w(bit t, logic [4:0] m, logic [9:0] n,
                                           logic [2:0] p, bit byp, bit en);
        logic [31:0] w;
        w = 32'(m) | (32'(n) << 8) | (32'(p) << 20);
        w[31] = byp; w[30] = en; w[28] = t;
        return w;
    endfunction

    function automatic logic [15:0] half_w(logic [7:0] r);
        return (16'(r) << 8) | 16'h0006;
    endfunction

    // cycle counter and ready driver
    always @(posedge clk) begin
        cyc <= cyc + 1;
        #1 wr_ready = ready_rand ? (($urandom % 4) != 0) : 1'b1;
    end

    // handshake recorder and R12 stall monitor
    logic       pend = 0;
    logic [2:0] pend_a;
    logic [31:0] pend_d;
    always @(negedge clk) begin
        if (rst_n) begin
            if (pend) begin
                check(wr_valid && wr_addr == pend_a && wr_data == pend_d, "R12",
                      "stalled offer", wr_data, pend_d);
            end
            pend = wr_valid && !wr_ready;
            pend_a = wr_addr; pend_d = wr_data;
            if (wr_valid && wr_ready && rec_n < 32) begin
                rec_a[rec_n] = wr_addr; rec_d[rec_n] = wr_data; rec_c[rec_n] = cyc;
                rec_n++;
            end
        end
    end

    // watchdog
    initial begin
        #1500000;
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    task automatic run(bit t, logic [4:0] m, logic [9:0] n, logic [2:0] p,
                       logic [3:0] cp, logic [31:0] r, logic [31:0] rb, bit mid);
        bit sk;
        int k, waitc;
        sk = t && rb[28];
        exp_n = 0;
        exp_a[exp_n] = 0; exp_d[exp_n] = 0; exp_n++;
        if (!sk) begin
            exp_a[exp_n] = 1; exp_d[exp_n] = base_w(t, m, n, p, 1, 0); exp_n++;
            exp_a[exp_n] = 2; exp_d[exp_n] = 32'(cp) << 8; exp_n++;
            exp_a[exp_n] = 1; exp_d[exp_n] = base_w(t, m, n, p, 1, 1); exp_n++;
            exp_a[exp_n] = 1; exp_d[exp_n] = base_w(t, m, n, p, 0, 1); exp_n++;
        end else if (rb != base_w(t, m, n, p, 0, 1)) begin
            exp_ok = 0;
        end
        exp_a[exp_n] = 3; exp_d[exp_n] = 32'h0001_0001; exp_n++;
        exp_a[exp_n] = 3; exp_d[exp_n] = {half_w(r[15:8]), half_w(r[7:0])}; exp_n++;
        exp_a[exp_n] = 4; exp_d[exp_n] = 32'h0001_0001; exp_n++;
        exp_a[exp_n] = 4; exp_d[exp_n] = {half_w(r[31:24]), half_w(r[23:16])}; exp_n++;
        exp_a[exp_n] = 0; exp_d[exp_n] = 1; exp_n++;

        @(posedge clk); #2;
        tgt = t; m_i = m; n_i = n; p_i = p; cp_i = cp; ratios = r; rdback = rb;
        rec_n = 0;
        start_i = 1;
        @(posedge clk); #2;
        start_i = 0;
        @(negedge clk);
        check(busy, "R13", "busy after start", 32'(busy), 1);
        check(!done, "R13", "done cleared by start", 32'(done), 0);
        if (mid) begin
            repeat (3) @(posedge clk);
            #2;
            m_i = ~m; n_i = ~n; p_i = ~p; cp_i = ~cp; ratios = ~r; tgt = ~t;
            start_i = 1;
            @(posedge clk); #2;
            start_i = 0;
        end
        waitc = 0;
        while (!done && waitc < 3000) begin
            @(negedge clk);
            waitc++;
        end
        check(done && !busy, "R8", "done raised, busy low", {busy, done}, 32'b01);
        check(skipped == sk, "R9", "skip flag", 32'(skipped), 32'(sk));
        check(cfg_ok == exp_ok, "R10", "valid flag", 32'(cfg_ok), 32'(exp_ok));
        check(rec_n == exp_n, "R9", "write count", rec_n, exp_n);
        for (int i = 0; i < exp_n && i < rec_n; i++) begin
            k = i;
            check(rec_a[i] == exp_a[i], (i == 0) ? "R2" : (!sk && i < 5) ? "R3" : "R7",
                  $sformatf("addr of write %0d", k), 32'(rec_a[i]), 32'(exp_a[i]));
            check(rec_d[i] == exp_d[i],
                  (i == 0) ? "R2" : (!sk && i == 1) ? "R3" : (!sk && i == 2) ? "R4" :
                  (!sk && i < 5) ? "R5" : (i == exp_n - 1) ? "R8" : "R7",
                  $sformatf("data of write %0d", k), rec_d[i], exp_d[i]);
        end
        if (!sk && rec_n > 5) begin
            if (ready_rand)
                check(rec_c[5] - rec_c[4] >= SET + 1, "R6", "settle gap (min)",
                      rec_c[5] - rec_c[4], SET + 1);
            else
                check(rec_c[5] - rec_c[4] == SET + 1, "R6", "settle gap (exact)",
                      rec_c[5] - rec_c[4], SET + 1);
        end
        if (mid) check(rec_n == exp_n, "R11", "start while busy ignored", rec_n, exp_n);
    endtask

    initial begin
        logic [4:0] rm; logic [9:0] rn; logic [2:0] rp; logic [3:0] rc;
        logic [31:0] rr, rb; bit rt;
        void'($urandom(32'd4711));
        repeat (3) @(posedge clk);
        #2 rst_n = 1;
        @(negedge clk);
        check(!busy && !done && !wr_valid && !skipped && cfg_ok, "R1", "reset state",
              {busy, done, wr_valid, skipped, cfg_ok}, 32'b00001);
        // directed cases
        run(0, 5'd12, 10'd408, 3'd0, 4'd8, 32'hCC64_3300, 32'h0, 0);
        run(1, 5'd31, 10'd1023, 3'd7, 4'd15, 32'hFF00_01FE, 32'h0, 0);
        run(0, 5'd1, 10'd1, 3'd0, 4'd0, 32'h0, 32'h1000_0000, 0);
        run(1, 5'd13, 10'd408, 3'd0, 4'd8, 32'h0102_0304,
            base_w(1, 5'd13, 10'd408, 3'd0, 0, 1), 0);
        run(0, 5'd26, 10'd600, 3'd1, 4'd3, 32'h1122_3344, 32'h0, 1);
        // random mix with random ready stalls
        ready_rand = 1;
        for (int it = 0; it < 24; it++) begin
            rm = 5'($urandom); rn = 10'($urandom); rp = 3'($urandom); rc = 4'($urandom);
            rr = $urandom; rt = 1'($urandom);
            case ($urandom % 3)
                0: rb = $urandom & 32'hEFFF_FFFF;
                1: rb = base_w(rt, rm, rn, rp, 0, 1) | 32'h1000_0000;
                default: rb = $urandom | 32'h1000_0000;
            endcase
            run(rt, rm, rn, rp, rc, rr, rb, (it % 7) == 3);
        end
        ready_rand = 0;
        // directed mismatch: valid flag clears and stays clear
        run(1, 5'd12, 10'd400, 3'd2, 4'd1, 32'h0, 32'h1000_0001, 0);
        run(1, 5'd12, 10'd400, 3'd2, 4'd1, 32'h0, base_w(1, 5'd12, 10'd400, 3'd2, 0, 1), 0);
        check(!cfg_ok, "R10", "valid flag sticky", 32'(cfg_ok), 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule